// File: doc/BRIEF.md
# Dual-Device SPI Master with Encoded Selects

This block is a CPU-programmed SPI master that shares one serial bus between a flash memory and an SD card. Software chooses the target device by writing a 2-bit select code. The code is decoded into two active-low chip-select lines, and a code can assert at most one of them. Software then writes a byte to the data register, which launches an 8-bit mode 0 exchange. While the exchange runs, software polls a busy bit; when busy is low it reads the received byte back from the same register.

The serial clock comes from the system clock through a programmable half-period count, so the divisor is always even. The busy state is also driven straight out to an activity LED, which acts as a disk light. While a transfer is running, the block ignores every register write, so software cannot disturb the bit stream or the device selection.

Top module: `spi_dual_master`

## Requirements
- R1: While reset is held and after it is released, `cs_flash_n` and `cs_sd_n` are both 1, `spi_sck` is 0, `led_activity` is 0 and the status register (address 3, bit 0) reads 0. The half-period register (address 2) reads `DEF_HALF` (default 3).
- R2: When the select register (address 1, bits [1:0]) holds 01, `cs_sd_n` is 0 and `cs_flash_n` is 1.
- R3: When the select register holds 10, `cs_flash_n` is 0 and `cs_sd_n` is 1.
- R4: When the select register holds 00 or 11, both chip selects are 1. No select code ever drives both chip selects to 0.
- R5: A write to the data register (address 0) while idle starts a transfer. Busy (status bit 0) is 1 from the clock edge that takes the write.
- R6: Bits leave on `spi_mosi` MSB first in mode 0. `spi_sck` is 0 whenever the block is idle. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is sampled on each rising edge of `spi_sck`.
- R7: Once busy has fallen, a read of address 0 returns the 8 bits sampled from `spi_miso`, first sample in bit 7.
- R8: With half-period value H, each `spi_sck` level lasts H+1 system cycles. Busy stays 1 for exactly 16*(H+1) cycles and falls at the eighth falling edge.
- R9: A write to any register while busy is 1 is ignored. This includes a write that is taken on the very edge where busy falls.
- R10: `led_activity` is 1 exactly while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 select, 2 half-period, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the devices |
| spi_miso | input | 1 | Serial data from the devices |
| cs_flash_n | output | 1 | Active-low flash select |
| cs_sd_n | output | 1 | Active-low SD card select |
| led_activity | output | 1 | Activity light, high while a transfer runs |

## Verification
A CPU register write and the final falling edge of the shift engine can land on the same clock edge. In that cycle busy is still high, so the write must be dropped, even though busy reads low one cycle later. The bench provokes this with a half-period of 0: it counts cycles from the start write and presents a half-period write exactly on the sixteenth edge. It then reads the register back to confirm that the old value survived, and checks that the LED went dark on that same edge.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

  typedef enum logic [1:0] {
    ADR_DATA = 2'd0,
    ADR_SEL  = 2'd1,
    ADR_HALF = 2'd2,
    ADR_STAT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic flash_n;
    logic sd_n;
  } cs_pair_t;

  // Select code to chip-select pair: 01 -> SD, 10 -> flash, others -> none
  function automatic cs_pair_t decode_sel(input logic [1:0] sel);
    cs_pair_t r;
    r.flash_n = 1'b1;
    r.sd_n    = 1'b1;
    case (sel)
      2'b01:   r.sd_n    = 1'b0;
      2'b10:   r.flash_n = 1'b0;
      default: ;
    endcase
    return r;
  endfunction

  // System cycles a whole transfer keeps busy high
  function automatic int unsigned xfer_cycles(input int unsigned bits,
                                              input int unsigned half);
    return 2 * bits * (half + 1);
  endfunction

endpackage

// File: rtl/spi_dual_regfile.sv
module spi_dual_regfile
  import spi_dual_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEF_HALF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              start_evt,
  output logic [1:0]        sel_q,
  output logic [DATA_W-1:0] half_q,
  output logic              cs_flash_n,
  output logic              cs_sd_n
);

  reg_addr_e adr;
  logic      wr_ok;
  cs_pair_t  cs;

  assign adr       = reg_addr_e'(reg_addr);
  assign wr_ok     = reg_wr & ~busy;
  assign start_evt = wr_ok & (adr == ADR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 2'b00;
      half_q <= DATA_W'(DEF_HALF);
    end else if (wr_ok) begin
      if (adr == ADR_SEL)  sel_q  <= reg_wdata[1:0];
      if (adr == ADR_HALF) half_q <= reg_wdata;
    end
  end

  assign cs         = decode_sel(sel_q);
  assign cs_flash_n = cs.flash_n;
  assign cs_sd_n    = cs.sd_n;

  always_comb begin
    reg_rdata = '0;
    case (adr)
      ADR_DATA: reg_rdata = rx_byte;
      ADR_SEL:  reg_rdata[1:0] = sel_q;
      ADR_HALF: reg_rdata = half_q;
      ADR_STAT: reg_rdata[0] = busy;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_dual_baud.sv
module spi_dual_baud #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] half,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = run & (cnt == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_dual_engine.sv
module spi_dual_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rise_evt,
  output logic              fall_evt,
  output logic              done_evt
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic              last_bit;

  assign rise_evt = busy & tick & ~sck;
  assign fall_evt = busy & tick & sck;
  assign last_bit = (bitcnt == BIT_W'(DATA_W - 1));
  assign done_evt = fall_evt & last_bit;
  assign mosi     = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitcnt  <= '0;
      busy    <= 1'b0;
      sck     <= 1'b0;
      rx_byte <= '0;
    end else if (start) begin
      shreg  <= load_data;
      bitcnt <= '0;
      busy   <= 1'b1;
      sck    <= 1'b0;
    end else begin
      if (rise_evt) begin
        sck     <= 1'b1;
        rx_byte <= {rx_byte[DATA_W-2:0], miso};
      end
      if (fall_evt) begin
        sck <= 1'b0;
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          shreg  <= shreg << 1;
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_dual_master.sv
module spi_dual_master #(
  parameter int DATA_W   = 8,
  parameter int DEF_HALF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              cs_flash_n,
  output logic              cs_sd_n,
  output logic              led_activity
);

  logic              start_evt;
  logic              busy;
  logic              tick;
  logic              rise_evt;
  logic              fall_evt;
  logic              done_evt;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] half_q;
  logic [DATA_W-1:0] rx_byte;

  spi_dual_regfile #(.DATA_W(DATA_W), .DEF_HALF(DEF_HALF)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .rx_byte    (rx_byte),
    .reg_rdata  (reg_rdata),
    .start_evt  (start_evt),
    .sel_q      (sel_q),
    .half_q     (half_q),
    .cs_flash_n (cs_flash_n),
    .cs_sd_n    (cs_sd_n)
  );

  spi_dual_baud #(.W(DATA_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .half  (half_q),
    .tick  (tick)
  );

  spi_dual_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .load_data (reg_wdata),
    .tick      (tick),
    .miso      (spi_miso),
    .busy      (busy),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .done_evt  (done_evt)
  );

  assign led_activity = busy;

endmodule

// File: rtl/spi_dual_chk.sv
module spi_dual_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              busy,
  input logic              start_evt,
  input logic              rise_evt,
  input logic              done_evt,
  input logic [1:0]        sel_q,
  input logic [DATA_W-1:0] half_q,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic              cs_flash_n,
  input logic              cs_sd_n
);

  // R4
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_flash_n && !cs_sd_n));

  // R2
  sd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b01) |-> (!cs_sd_n && cs_flash_n));

  // R3
  flash_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b10) |-> (!cs_flash_n && cs_sd_n));

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R6
  rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> spi_sck);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && !spi_sck));

  // R9
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> ($stable(half_q) && $stable(sel_q)));

endmodule

bind spi_dual_master spi_dual_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .busy       (busy),
  .start_evt  (start_evt),
  .rise_evt   (rise_evt),
  .done_evt   (done_evt),
  .sel_q      (sel_q),
  .half_q     (half_q),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi),
  .cs_flash_n (cs_flash_n),
  .cs_sd_n    (cs_sd_n)
);

// File: tb/spi_dual_master_tb.sv
module spi_dual_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_mosi, spi_miso;
  logic       cs_flash_n, cs_sd_n, led_activity;

  int checks = 0;
  int fails = 0;
  int busy_cnt = 0;
  logic [7:0] slave_sh = 8'h00;
  logic [7:0] mosi_cap = 8'h00;

  always #4 clk = ~clk;  // 125 MHz

  spi_dual_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cs_flash_n(cs_flash_n),
    .cs_sd_n(cs_sd_n), .led_activity(led_activity)
  );

  // Mode 0 slave model: drive on falling edge, capture on rising edge
  assign spi_miso = slave_sh[7];
  always @(negedge spi_sck) slave_sh <= slave_sh << 1;
  always @(posedge spi_sck) mosi_cap <= {mosi_cap[6:0], spi_mosi};
  always @(negedge clk) if (led_activity) busy_cnt <= busy_cnt + 1;

  // {sel, half, tx byte, slave byte}
  localparam logic [31:0] VECS [6] = '{
    {8'h01, 8'h00, 8'hA5, 8'h3C},
    {8'h02, 8'h01, 8'h5A, 8'hC3},
    {8'h00, 8'h02, 8'hFF, 8'h00},
    {8'h03, 8'h03, 8'h00, 8'hFF},
    {8'h01, 8'h05, 8'h81, 8'h7E},
    {8'h02, 8'h00, 8'h13, 8'hE4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (led_activity) @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 cs_flash_n in reset", cs_flash_n, 1);
    chk("R1 cs_sd_n in reset", cs_sd_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs pair after reset", {cs_flash_n, cs_sd_n}, 2'b11);
    chk("R1 sck idle", spi_sck, 0);
    chk("R1 led off", led_activity, 0);
    rd(2'd3, rv); chk("R1 status busy", rv, 8'h00);
    rd(2'd2, rv); chk("R1 half default", rv, 8'h03);

    // Table walk
    for (int i = 0; i < 6; i++) begin
      logic [7:0] sel, half, tx, sl;
      {sel, half, tx, sl} = VECS[i];
      wr(2'd1, sel);
      wr(2'd2, half);
      @(negedge clk);
      chk((sel == 1) ? "R2 sd select" : (sel == 2) ? "R3 flash select" : "R4 none selected",
          {cs_flash_n, cs_sd_n}, {sel[1:0] != 2'b10, sel[1:0] != 2'b01});
      slave_sh = sl;
      busy_cnt = 0;
      wr(2'd0, tx);
      chk("R10 led during transfer", led_activity, 1);
      rd(2'd3, rv); chk("R5 status busy set", rv, 8'h01);
      wait_idle();
      @(negedge clk);
      chk("R8 busy length", busy_cnt, 16 * (half + 1));
      chk("R6 mosi byte msb first", mosi_cap, tx);
      chk("R6 sck idle after", spi_sck, 0);
      rd(2'd0, rv); chk("R7 received byte", rv, sl);
      chk("R10 led off after", led_activity, 0);
    end

    // R9: writes during a transfer are ignored
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h03);
    slave_sh = 8'h96;
    busy_cnt = 0;
    wr(2'd0, 8'hC5);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h02);
    wait_idle();
    @(negedge clk);
    chk("R9 no restart, length", busy_cnt, 64);
    chk("R9 mosi unchanged", mosi_cap, 8'hC5);
    rd(2'd2, rv); chk("R9 half kept", rv, 8'h03);
    rd(2'd1, rv); chk("R9 select kept", rv, 8'h01);
    chk("R9 sd still selected", {cs_flash_n, cs_sd_n}, 2'b10);
    rd(2'd0, rv); chk("R9 rx byte", rv, 8'h96);

    // R9: write taken on the same edge busy falls (half 0 => 16 cycles)
    wr(2'd2, 8'h00);
    slave_sh = 8'h00;
    busy_cnt = 0;
    wr(2'd0, 8'h3A);
    repeat (14) @(negedge clk);
    wr(2'd2, 8'h09);
    chk("R8 busy fell on final edge", led_activity, 0);
    chk("R8 collision length", busy_cnt, 16);
    rd(2'd2, rv); chk("R9 collision write dropped", rv, 8'h00);
    wr(2'd2, 8'h09);
    rd(2'd2, rv); chk("R9 idle write accepted", rv, 8'h09);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule